// File: doc/BRIEF.md
# SCSI Initiator Command-Complete Sequencer

This block is the initiator-side sequencer that closes out a SCSI command. When the host issues the command-complete command, the block takes one status byte from the target and then the message-in bytes, one handshake at a time. Each byte goes into a small receive FIFO. The host or a DMA engine drains that FIFO. After the final message byte the block keeps ACK asserted. This gives the host time to raise ATN and refuse the message. A separate accept command then releases ACK. Three things end a sequence early and raise a sticky interrupt bit: the target leaving the expected phase, the target dropping BSY, or the host issuing a command that does not fit the current state.

States: `S_IDLE` waits for a command. On command-complete it moves to `S_STAT_WAIT`. That state captures the status byte into `S_STAT_ACK`, or goes back to `S_IDLE` on a wrong phase. `S_STAT_ACK` moves to `S_MSG_WAIT` once REQ falls. `S_MSG_WAIT` captures a message byte. A byte that is not the last goes to `S_MSG_ACK`, and the last byte goes to `S_MSG_HOLD`. On a wrong phase, `S_MSG_WAIT` goes back to `S_IDLE`. `S_MSG_ACK` returns to `S_MSG_WAIT` once REQ falls. `S_MSG_HOLD` goes to `S_IDLE` on the accept command. A BSY drop sends every state except `S_IDLE` straight to `S_IDLE`.

The phase lines are read as {msg, cd, io}. All bus signals are logical levels that are active high and already synchronous to `clk`.

Top module: `scsi_cc_seq`

## Requirements
- R1: After reset, ACK and ATN are low, all five interrupt flags are clear, and the FIFO is empty.
- R2: In the status wait, REQ high with phase {msg,cd,io}=3'b011 captures `bus_data` into the FIFO. ACK is high from the next cycle. ACK goes low one cycle after REQ is seen low, and the block then waits for message-in.
- R3: In the status wait, REQ high with any other phase sets flag bit 1 (bus service). The sequence then ends with no byte captured.
- R4: After the status byte, REQ high with a phase other than message-in (3'b111) sets flag bit 1 and ends the sequence early.
- R5: When the final message byte is captured, flag bit 0 (function complete) is set. ACK then stays high whatever REQ does.
- R6: The accept command in the hold state drops ACK on the next cycle. An ATN raised earlier through `set_atn` stays asserted, which is how the host rejects the message.
- R7: If BSY is low while a sequence is active, flag bit 2 (disconnected) is set. ACK and ATN are then low from the next cycle and the block returns to idle.
- R8: With DMA latched on at command start, no byte is captured while the FIFO holds data. `dma_req` equals `dma_en` AND not FIFO-empty.
- R9: With DMA, `msg_len` is loaded at command start as the message byte count, and 0 counts as 1. Bytes before the last one get a plain ACK pulse. The byte that brings the count to its end enters the hold state.
- R10: Without DMA, every captured byte sets flag bit 3 (byte ready), and the first message byte is treated as the final one.
- R11: Flag bits stay set until `int_clr`. A flag set in the same cycle as `int_clr` stays set.
- R12: Command-complete outside idle, or accept outside the hold state, sets flag bit 4 (illegal command) and does not change the sequence.
- R13: Without DMA, no byte is captured while the FIFO is full. Capture happens once a slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_complete | input | 1 | Pulse: start the status/message sequence |
| cmd_accept | input | 1 | Pulse: release ACK held on the final message byte |
| set_atn | input | 1 | Pulse: raise ATN |
| int_clr | input | 1 | Pulse: clear all interrupt flags |
| dma_en | input | 1 | DMA mode, latched at command start |
| msg_len | input | 8 | Message byte count for DMA mode |
| bus_bsy | input | 1 | Target BSY |
| bus_req | input | 1 | Target REQ |
| bus_msg | input | 1 | Phase line MSG |
| bus_cd | input | 1 | Phase line C/D |
| bus_io | input | 1 | Phase line I/O |
| bus_data | input | 8 | Bus data byte |
| bus_ack | output | 1 | Initiator ACK |
| bus_atn | output | 1 | Initiator ATN |
| fifo_pop | input | 1 | Remove the head byte (host read or DMA acknowledge) |
| fifo_data | output | 8 | Head byte of the receive FIFO |
| fifo_empty | output | 1 | FIFO holds no byte |
| dma_req | output | 1 | DMA request for the head byte |
| irq_flags | output | 5 | Sticky flags: 0 function complete, 1 bus service, 2 disconnected, 3 byte ready, 4 illegal command |
| irq | output | 1 | OR of all flags |

## Verification
The bench targets the message-in wait in DMA mode with a byte still in the FIFO. A design that ignored the gate would ACK a second byte early and overrun the one-at-a-time rule. It also targets the hold state: REQ falling there must not drop ACK, and a design that treated the last byte like the others would leave no window for ATN. Further cases are a BSY drop while ACK is high (a faulty design leaves ACK or ATN stuck), a full FIFO without DMA (bytes lost or overwritten), a `msg_len` of zero (a naive counter would wrap and wait for 256 bytes), and an illegal command arriving in the same cycle as `int_clr` (the flag would vanish).

// File: rtl/scsi_cc_pkg.sv
package scsi_cc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAT_WAIT,
        S_STAT_ACK,
        S_MSG_WAIT,
        S_MSG_ACK,
        S_MSG_HOLD
    } seq_state_t;

    // phase code {msg, cd, io}
    localparam logic [2:0] PH_STATUS = 3'b011;
    localparam logic [2:0] PH_MSG_IN = 3'b111;

    localparam int IRQ_FC   = 0;
    localparam int IRQ_BS   = 1;
    localparam int IRQ_DISC = 2;
    localparam int IRQ_BYTE = 3;
    localparam int IRQ_ILL  = 4;
    localparam int IRQ_N    = 5;

endpackage

// File: rtl/scsi_cc_fifo.sv
module scsi_cc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty    = (cnt == '0);
    assign full     = (cnt == FULL_CNT);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // the sequencer must never offer a byte the buffer cannot hold
    p_no_push_full_r13: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/scsi_cc_irq.sv
module scsi_cc_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
        p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr) |=> flags[i]);
    end

endmodule

// File: rtl/scsi_cc_fsm.sv
module scsi_cc_fsm
    import scsi_cc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_complete,
    input  logic             cmd_accept,
    input  logic             set_atn,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] msg_len,
    input  logic             bus_bsy,
    input  logic             bus_req,
    input  logic [2:0]       phase,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    output logic             push,
    output logic             ack_o,
    output logic             atn_o,
    output logic [IRQ_N-1:0] ev
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       st, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             dma_l, dma_nxt;
    logic             gate;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= ONE;
            dma_l <= 1'b0;
            atn_o <= 1'b0;
        end else begin
            st    <= nxt;
            cnt   <= cnt_nxt;
            dma_l <= dma_nxt;
            if (ev[IRQ_DISC])  atn_o <= 1'b0;
            else if (set_atn)  atn_o <= 1'b1;
        end
    end

    assign ack_o = (st == S_STAT_ACK) || (st == S_MSG_ACK) || (st == S_MSG_HOLD);

    // next state and outputs
    always_comb begin
        nxt     = st;
        cnt_nxt = cnt;
        dma_nxt = dma_l;
        push    = 1'b0;
        ev      = '0;
        gate    = dma_l ? fifo_empty : !fifo_full;
        unique case (st)
            S_IDLE: begin
                if (cmd_complete) begin
                    nxt     = S_STAT_WAIT;
                    dma_nxt = dma_en;
                    cnt_nxt = (dma_en && msg_len != '0) ? msg_len : ONE;
                end
            end
            S_STAT_WAIT: begin
                if (!bus_bsy) begin
                    ev[IRQ_DISC] = 1'b1;
                    nxt          = S_IDLE;
                end else if (bus_req) begin
                    if (phase != PH_STATUS) begin
                        ev[IRQ_BS] = 1'b1;
                        nxt        = S_IDLE;
                    end else if (gate) begin
                        push         = 1'b1;
                        ev[IRQ_BYTE] = !dma_l;
                        nxt          = S_STAT_ACK;
                    end
                end
            end
            S_STAT_ACK: begin
                if (!bus_bsy) begin
                    ev[IRQ_DISC] = 1'b1;
                    nxt          = S_IDLE;
                end else if (!bus_req) begin
                    nxt = S_MSG_WAIT;
                end
            end
            S_MSG_WAIT: begin
                if (!bus_bsy) begin
                    ev[IRQ_DISC] = 1'b1;
                    nxt          = S_IDLE;
                end else if (bus_req) begin
                    if (phase != PH_MSG_IN) begin
                        ev[IRQ_BS] = 1'b1;
                        nxt        = S_IDLE;
                    end else if (gate) begin
                        push         = 1'b1;
                        ev[IRQ_BYTE] = !dma_l;
                        if (cnt <= ONE) begin
                            ev[IRQ_FC] = 1'b1;
                            nxt        = S_MSG_HOLD;
                        end else begin
                            cnt_nxt = cnt - ONE;
                            nxt     = S_MSG_ACK;
                        end
                    end
                end
            end
            S_MSG_ACK: begin
                if (!bus_bsy) begin
                    ev[IRQ_DISC] = 1'b1;
                    nxt          = S_IDLE;
                end else if (!bus_req) begin
                    nxt = S_MSG_WAIT;
                end
            end
            S_MSG_HOLD: begin
                if (!bus_bsy) begin
                    ev[IRQ_DISC] = 1'b1;
                    nxt          = S_IDLE;
                end else if (cmd_accept) begin
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
        ev[IRQ_ILL] = (cmd_complete && st != S_IDLE) ||
                      (cmd_accept && st != S_MSG_HOLD);
    end

    p_fc_holds_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev[IRQ_FC] |=> ack_o);
    p_accept_drops_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MSG_HOLD && cmd_accept && bus_bsy) |=> !ack_o);
    p_disc_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && !bus_bsy) |=> (!ack_o && !atn_o));
    p_dma_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && dma_l) |-> fifo_empty);

endmodule

// File: rtl/scsi_cc_seq.sv
module scsi_cc_seq
    import scsi_cc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_complete,
    input  logic             cmd_accept,
    input  logic             set_atn,
    input  logic             int_clr,
    input  logic             dma_en,
    input  logic [CNT_W-1:0] msg_len,
    input  logic             bus_bsy,
    input  logic             bus_req,
    input  logic             bus_msg,
    input  logic             bus_cd,
    input  logic             bus_io,
    input  logic [DW-1:0]    bus_data,
    output logic             bus_ack,
    output logic             bus_atn,
    input  logic             fifo_pop,
    output logic [DW-1:0]    fifo_data,
    output logic             fifo_empty,
    output logic             dma_req,
    output logic [IRQ_N-1:0] irq_flags,
    output logic             irq
);
    logic             push, full;
    logic [IRQ_N-1:0] ev;

    scsi_cc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_complete (cmd_complete),
        .cmd_accept   (cmd_accept),
        .set_atn      (set_atn),
        .dma_en       (dma_en),
        .msg_len      (msg_len),
        .bus_bsy      (bus_bsy),
        .bus_req      (bus_req),
        .phase        ({bus_msg, bus_cd, bus_io}),
        .fifo_empty   (fifo_empty),
        .fifo_full    (full),
        .push         (push),
        .ack_o        (bus_ack),
        .atn_o        (bus_atn),
        .ev           (ev)
    );

    scsi_cc_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (bus_data),
        .pop       (fifo_pop),
        .pop_data  (fifo_data),
        .empty     (fifo_empty),
        .full      (full)
    );

    scsi_cc_irq #(.N(IRQ_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev),
        .clr   (int_clr),
        .flags (irq_flags)
    );

    assign dma_req = dma_en && !fifo_empty;
    assign irq     = |irq_flags;

endmodule

// File: tb/scsi_cc_seq_tb_top.sv
module scsi_cc_seq_tb_top;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_complete = 0, cmd_accept = 0, set_atn = 0, int_clr = 0;
    logic       dma_en = 0;
    logic [7:0] msg_len = 0;
    logic       bus_bsy = 1, bus_req = 0, bus_msg = 0, bus_cd = 0, bus_io = 0;
    logic [7:0] bus_data = 0;
    logic       fifo_pop = 0;
    logic       bus_ack, bus_atn, fifo_empty, dma_req, irq;
    logic [7:0] fifo_data;
    logic [4:0] irq_flags;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    scsi_cc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_complete(cmd_complete), .cmd_accept(cmd_accept),
        .set_atn(set_atn), .int_clr(int_clr), .dma_en(dma_en), .msg_len(msg_len),
        .bus_bsy(bus_bsy), .bus_req(bus_req), .bus_msg(bus_msg), .bus_cd(bus_cd),
        .bus_io(bus_io), .bus_data(bus_data), .bus_ack(bus_ack), .bus_atn(bus_atn),
        .fifo_pop(fifo_pop), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .dma_req(dma_req), .irq_flags(irq_flags), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    // m_st: 0 idle, 1 status wait, 2 status ack, 3 msg wait, 4 msg ack, 5 hold
    int               m_st = 0;
    int               m_left = 1;
    bit               m_dma = 0;
    bit               m_atn = 0;
    bit [4:0]         m_irq = 0;
    byte unsigned     m_q[$];

    always @(posedge clk) begin
        bit [4:0] e;
        bit       take, ok, popd;
        int       ph;
        if (!rst_n) begin
            m_st = 0; m_left = 1; m_dma = 0; m_atn = 0; m_irq = 0;
            m_q.delete();
        end else begin
            e = 0; take = 0;
            ph = {bus_msg, bus_cd, bus_io};
            ok = m_dma ? (m_q.size() == 0) : (m_q.size() < DEPTH);
            if ((cmd_complete && m_st != 0) || (cmd_accept && m_st != 5)) e[4] = 1;
            if (m_st != 0 && !bus_bsy) begin
                e[2] = 1; m_st = 0;
            end else if (m_st == 0) begin
                if (cmd_complete) begin
                    m_st = 1; m_dma = dma_en;
                    m_left = (dma_en && msg_len != 0) ? int'(msg_len) : 1;
                end
            end else if (m_st == 1 || m_st == 3) begin
                if (bus_req) begin
                    if (ph != ((m_st == 1) ? 3 : 7)) begin
                        e[1] = 1; m_st = 0;
                    end else if (ok) begin
                        take = 1; e[3] = !m_dma;
                        if (m_st == 1) m_st = 2;
                        else if (m_left <= 1) begin m_st = 5; e[0] = 1; end
                        else begin m_left--; m_st = 4; end
                    end
                end
            end else if (m_st == 2 || m_st == 4) begin
                if (!bus_req) m_st = 3;
            end else if (m_st == 5) begin
                if (cmd_accept) m_st = 0;
            end
            popd = fifo_pop && m_q.size() > 0;
            if (popd) void'(m_q.pop_front());
            if (take) m_q.push_back(bus_data);
            if (e[2]) m_atn = 0; else if (set_atn) m_atn = 1;
            m_irq = (int_clr ? 5'd0 : m_irq) | e;
        end
    end

    // compare on every clock, half a period after the edge
    always @(negedge clk) begin
        bit e_ack, e_empty;
        if (rst_n) begin
            e_ack   = (m_st == 2 || m_st == 4 || m_st == 5);
            e_empty = (m_q.size() == 0);
            total++;
            if (bus_ack !== e_ack || bus_atn !== m_atn || irq_flags !== m_irq ||
                irq !== (|m_irq) || fifo_empty !== e_empty ||
                dma_req !== (dma_en && !e_empty) ||
                (!e_empty && fifo_data !== m_q[0])) begin
                bad++;
                $display("FAIL %s model t=%0t: ack=%b/%b atn=%b/%b flags=%b/%b empty=%b/%b (actual/expected)",
                         cur_req, $time, bus_ack, e_ack, bus_atn, m_atn, irq_flags, m_irq,
                         fifo_empty, e_empty);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic step(int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic check(string tag, int got, int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic set_phase(logic [2:0] p);
        {bus_msg, bus_cd, bus_io} = p;
    endtask

    task automatic start_cmd();
        cmd_complete = 1; step(1); cmd_complete = 0;
    endtask

    task automatic accept();
        cmd_accept = 1; step(1); cmd_accept = 0;
    endtask

    task automatic clear_irq();
        int_clr = 1; step(1); int_clr = 0;
    endtask

    task automatic pop1();
        fifo_pop = 1; step(1); fifo_pop = 0;
    endtask

    task automatic drain();
        while (!fifo_empty) pop1();
        step(1);
    endtask

    // one byte: REQ high until captured, then REQ low
    task automatic xfer(logic [2:0] p, logic [7:0] d);
        set_phase(p); bus_data = d; bus_req = 1; step(3);
        bus_req = 0; step(2);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        cur_req = "R1";
        check("R1 ack", bus_ack, 0);
        check("R1 atn", bus_atn, 0);
        check("R1 flags", irq_flags, 0);
        check("R1 empty", fifo_empty, 1);

        // non-DMA normal flow
        cur_req = "R2";
        start_cmd();
        set_phase(3'b011); bus_data = 8'h5A; bus_req = 1; step(3);
        check("R2 ack on status", bus_ack, 1);
        check("R2 status byte", fifo_data, 8'h5A);
        check("R10 byte flag", irq_flags[3], 1);
        bus_req = 0; step(2);
        check("R2 ack released", bus_ack, 0);
        cur_req = "R5";
        set_phase(3'b111); bus_data = 8'h07; bus_req = 1; step(3);
        check("R5 fc flag", irq_flags[0], 1);
        bus_req = 0; step(3);
        check("R5 ack held", bus_ack, 1);
        check("R10 single msg byte is last", irq_flags[0], 1);
        check("R2 head", fifo_data, 8'h5A);
        pop1();
        check("R2 second", fifo_data, 8'h07);
        pop1();
        cur_req = "R6";
        set_atn = 1; step(1); set_atn = 0;
        accept(); step(1);
        check("R6 ack dropped", bus_ack, 0);
        check("R6 atn kept", bus_atn, 1);
        cur_req = "R11";
        check("R11 sticky", irq_flags[0], 1);
        clear_irq(); step(1);
        check("R11 cleared", irq_flags, 0);

        // wrong phase instead of status
        cur_req = "R3";
        start_cmd();
        xfer(3'b111, 8'hEE);
        check("R3 bus service", irq_flags[1], 1);
        check("R3 no byte", fifo_empty, 1);
        check("R3 ack", bus_ack, 0);
        clear_irq();

        // no message-in after status
        cur_req = "R4";
        start_cmd();
        xfer(3'b011, 8'h02);
        set_phase(3'b000); bus_req = 1; step(3);
        check("R4 bus service", irq_flags[1], 1);
        check("R4 ack", bus_ack, 0);
        bus_req = 0; step(1);
        drain();
        cur_req = "R12";
        accept(); step(1);
        check("R12 accept outside hold", irq_flags[4], 1);
        clear_irq();

        // disconnect while ACK is high
        cur_req = "R7";
        start_cmd();
        set_phase(3'b011); bus_data = 8'h33; bus_req = 1; step(3);
        set_atn = 1; step(1); set_atn = 0;
        bus_bsy = 0; step(2);
        check("R7 disc flag", irq_flags[2], 1);
        check("R7 ack low", bus_ack, 0);
        check("R7 atn low", bus_atn, 0);
        bus_bsy = 1; bus_req = 0; step(1);
        drain(); clear_irq();

        // illegal restart, then normal finish; set wins over clear
        cur_req = "R12";
        start_cmd();
        start_cmd(); step(1);
        check("R12 restart flagged", irq_flags[4], 1);
        xfer(3'b011, 8'h44);
        xfer(3'b111, 8'h45);
        check("R12 sequence intact", bus_ack, 1);
        check("R12 fc", irq_flags[0], 1);
        cur_req = "R11";
        cmd_complete = 1; int_clr = 1; step(1); cmd_complete = 0; int_clr = 0; step(1);
        check("R11 set beats clear", irq_flags, 5'b10000);
        cur_req = "R7";
        bus_bsy = 0; step(2);
        check("R7 disc in hold", bus_ack, 0);
        bus_bsy = 1; step(1);
        drain(); clear_irq();

        // DMA, three message bytes
        cur_req = "R8";
        dma_en = 1; msg_len = 3;
        start_cmd();
        xfer(3'b011, 8'h11);
        check("R8 dma_req", dma_req, 1);
        set_phase(3'b111); bus_data = 8'h21; bus_req = 1; step(4);
        check("R8 gated ack", bus_ack, 0);
        check("R8 still head", fifo_data, 8'h11);
        pop1(); step(1);
        check("R8 taken after empty", bus_ack, 1);
        cur_req = "R9";
        bus_req = 0; step(2);
        check("R9 nonfinal ack pulse", bus_ack, 0);
        check("R9 no fc yet", irq_flags[0], 0);
        pop1();
        xfer(3'b111, 8'h22);
        check("R9 second not final", bus_ack, 0);
        pop1();
        xfer(3'b111, 8'h23);
        check("R9 final held", bus_ack, 1);
        check("R9 fc", irq_flags[0], 1);
        check("R10 no byte flag in dma", irq_flags[3], 0);
        accept(); drain(); clear_irq();

        // DMA with zero length acts as one byte
        msg_len = 0;
        start_cmd();
        xfer(3'b011, 8'h51); pop1();
        xfer(3'b111, 8'h52);
        check("R9 zero length final", irq_flags[0], 1);
        accept(); drain(); clear_irq();
        dma_en = 0;

        // non-DMA with a full FIFO
        cur_req = "R13";
        repeat (2) begin
            start_cmd();
            xfer(3'b011, 8'h61);
            xfer(3'b111, 8'h62);
            accept();
        end
        start_cmd();
        set_phase(3'b011); bus_data = 8'h63; bus_req = 1; step(4);
        check("R13 full blocks capture", bus_ack, 0);
        pop1(); step(1);
        check("R13 captured after pop", bus_ack, 1);
        bus_req = 0; bus_bsy = 0; step(2);
        bus_bsy = 1;
        drain(); clear_irq(); step(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule